// File: doc/BRIEF.md
# Command-Driven I2C Bus Master

This block is an I2C bus master that software steers through four byte-wide registers: a target address with a direction flag, a one-byte data buffer, a command/status location and an SCL divider. Every command write with the run flag set makes the block move exactly one byte on the bus. Two flags in the same write decide whether a start condition comes first and whether a stop condition follows. Software can therefore build single-byte transfers, multi-byte bursts and combined write-then-read sequences by issuing one command per byte.

Between commands of a burst the master keeps ownership of the bus with SCL pulled low. Completion is found by polling a busy flag. An error flag reports a target that did not acknowledge. SCL and SDA are open-drain: the block only drives enables that pull the lines low and reads SDA back. The SCL period is set at run time from the system clock.

Top module: `i2c_cmd_master`

## Requirements
- R1: Register offsets: 0 = target address (7-bit address in bits 7:1, bit 0 = direction, 1 = read), 1 = data buffer, 2 = command on write and status on read, 3 = SCL divider. Command bits: RUN bit 0, START bit 1, STOP bit 2, ACK bit 3. Status bits: BUSY bit 0, ERROR bit 1. After reset the divider reads 4, every other register reads 0 and both bus enables are 0.
- R2: A command write with RUN=1 shows BUSY=1 on a status read in the very cycle of that write, and BUSY stays 1 until the byte (and any stop) is finished.
- R3: A command with RUN, START and STOP set while the bus is free produces a start, the address byte (address and direction bit), one data byte from the buffer, and a stop, then releases both lines.
- R4: A command with STOP=0 ends after the acknowledge bit with SCL held low and no stop; a following command with START=0 sends only a data byte on the held bus.
- R5: A command with START=1 while the bus is held issues a repeated start with no stop in between.
- R6: With direction = read, the received byte lands in the data buffer when BUSY clears; ACK=1 makes the master pull SDA low in the ninth clock, ACK=0 leaves SDA released there.
- R7: A NACK on the address byte sets ERROR, is followed by a stop and a free bus; the next accepted command shows ERROR=0 from its own write cycle on.
- R8: A NACK on a written data byte sets ERROR and is followed by a stop, even when that command had STOP=0.
- R9: SDA changes while SCL is high only to form a start or a stop condition.
- R10: Within a transfer, successive SCL rising edges are 4*(divider+1) clock cycles apart.
- R11: While BUSY is 1, writes to the command, address, data and divider registers are ignored.
- R12: Bit 4 of the command (high-speed flag) has no effect, and a command with RUN=0 starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register offset |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data, combinational from offset |
| scl_oe_o | output | 1 | 1 pulls SCL low |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| sda_i | input | 1 | Sampled SDA line level |

## Verification
A wrong sequencer state shows within one SCL quarter period as a missing or extra start or stop seen by the bench's target model, as a byte that arrives shifted or corrupted, or as SCL left released when a burst should hold it. A wrong acknowledge decision shows when BUSY clears, as a stale ERROR flag or a stop that came too early or not at all. Divider faults show as a wrong spacing of SCL rising edges, measured on every transfer of a sweep over divider values, and a late BUSY shows in the very write cycle of the command.

// File: rtl/i2c_cmd_pkg.sv
package i2c_cmd_pkg;
  localparam logic [1:0] REG_TADDR = 2'd0;
  localparam logic [1:0] REG_DATA  = 2'd1;
  localparam logic [1:0] REG_CMD   = 2'd2;
  localparam logic [1:0] REG_DIV   = 2'd3;

  localparam int CMD_RUN   = 0;
  localparam int CMD_START = 1;
  localparam int CMD_STOP  = 2;
  localparam int CMD_ACK   = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HOLD,
    ST_START,
    ST_ADDR,
    ST_DATA,
    ST_STOP
  } eng_state_e;
endpackage

// File: rtl/i2c_quarter_tick.sv
module i2c_quarter_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!en_i || tick_o) cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;
  end

  p_cnt_in_range_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |-> (cnt_q <= div_i));
endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine
  import i2c_cmd_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              go_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              ack_i,
  input  logic [BYTE_W-1:0] addr_byte_i,
  input  logic [BYTE_W-1:0] tx_byte_i,
  input  logic              sda_i,
  output logic              active_o,
  output logic              err_o,
  output logic [BYTE_W-1:0] rx_byte_o,
  output logic              rx_valid_o,
  output logic              scl_low_o,
  output logic              sda_low_o
);
  localparam int CW = $clog2(BYTE_W + 1);

  eng_state_e        state_q;
  logic [1:0]        q_q;
  logic [CW-1:0]     bit_q;
  logic [BYTE_W-1:0] sh_q, addr_q, tx_q, rx_q;
  logic              rd_q, stop_q, ack_q, nack_q;
  logic              scl_low_q, sda_low_q, err_q, rx_valid_q;
  logic              last_bit, tx_mode;

  assign last_bit   = (bit_q == CW'(BYTE_W));
  assign tx_mode    = (state_q == ST_ADDR) || !rd_q;
  assign active_o   = (state_q != ST_IDLE) && (state_q != ST_HOLD);
  assign err_o      = err_q;
  assign rx_byte_o  = rx_q;
  assign rx_valid_o = rx_valid_q;
  assign scl_low_o  = scl_low_q;
  assign sda_low_o  = sda_low_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      q_q        <= '0;
      bit_q      <= '0;
      sh_q       <= '0;
      addr_q     <= '0;
      tx_q       <= '0;
      rx_q       <= '0;
      rd_q       <= 1'b0;
      stop_q     <= 1'b0;
      ack_q      <= 1'b0;
      nack_q     <= 1'b0;
      scl_low_q  <= 1'b0;
      sda_low_q  <= 1'b0;
      err_q      <= 1'b0;
      rx_valid_q <= 1'b0;
    end else begin
      err_q      <= 1'b0;
      rx_valid_q <= 1'b0;
      if (go_i) begin
        stop_q <= stop_i;
        ack_q  <= ack_i;
        tx_q   <= tx_byte_i;
        sh_q   <= tx_byte_i;
        q_q    <= '0;
        bit_q  <= '0;
        // a free bus always needs a start condition
        if (start_i || state_q == ST_IDLE) begin
          state_q <= ST_START;
          addr_q  <= addr_byte_i;
          rd_q    <= addr_byte_i[0];
        end else begin
          state_q <= ST_DATA;
        end
      end else if (tick_i) begin
        q_q <= q_q + 2'd1;
        case (state_q)
          ST_START: begin
            case (q_q)
              2'd0: sda_low_q <= 1'b0;
              2'd1: scl_low_q <= 1'b0;
              2'd2: sda_low_q <= 1'b1;
              default: begin
                scl_low_q <= 1'b1;
                sh_q      <= addr_q;
                bit_q     <= '0;
                state_q   <= ST_ADDR;
              end
            endcase
          end
          ST_ADDR, ST_DATA: begin
            case (q_q)
              2'd0: sda_low_q <= last_bit ? ((state_q == ST_DATA) && rd_q && ack_q)
                                          : (tx_mode && !sh_q[BYTE_W-1]);
              2'd1: scl_low_q <= 1'b0;
              2'd2: begin
                if (last_bit) nack_q <= sda_i;
                else          sh_q   <= {sh_q[BYTE_W-2:0], sda_i};
              end
              default: begin
                scl_low_q <= 1'b1;
                if (!last_bit) begin
                  bit_q <= bit_q + 1'b1;
                end else begin
                  bit_q <= '0;
                  if (state_q == ST_ADDR) begin
                    if (nack_q) begin
                      err_q   <= 1'b1;
                      state_q <= ST_STOP;
                    end else begin
                      sh_q    <= tx_q;
                      state_q <= ST_DATA;
                    end
                  end else if (!rd_q && nack_q) begin
                    err_q   <= 1'b1;
                    state_q <= ST_STOP;
                  end else begin
                    if (rd_q) begin
                      rx_q       <= sh_q;
                      rx_valid_q <= 1'b1;
                    end
                    state_q <= stop_q ? ST_STOP : ST_HOLD;
                  end
                end
              end
            endcase
          end
          ST_STOP: begin
            case (q_q)
              2'd0: sda_low_q <= 1'b1;
              2'd1: scl_low_q <= 1'b0;
              2'd2: sda_low_q <= 1'b0;
              default: state_q <= ST_IDLE;
            endcase
          end
          default: ;
        endcase
      end
    end
  end

  p_sda_stable_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!scl_low_q && !$past(scl_low_q) && $past(state_q) != ST_START &&
     $past(state_q) != ST_STOP) |-> $stable(sda_low_q));

  p_hold_scl_low_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HOLD) |-> scl_low_q);

  p_idle_released_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> (!scl_low_q && !sda_low_q));

  p_addr_nack_stop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ADDR && tick_i && !go_i && q_q == 2'd3 && last_bit && nack_q)
      |=> (state_q == ST_STOP));
endmodule

// File: rtl/i2c_cmd_master.sv
module i2c_cmd_master
  import i2c_cmd_pkg::*;
#(
  parameter int             DIV_W   = 8,
  parameter logic [DIV_W-1:0] DIV_RST = DIV_W'(4)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       reg_we_i,
  input  logic [1:0] reg_addr_i,
  input  logic [7:0] reg_wdata_i,
  output logic [7:0] reg_rdata_o,
  output logic       scl_oe_o,
  output logic       sda_oe_o,
  input  logic       sda_i
);
  localparam int BYTE_W = 8;

  logic [BYTE_W-1:0] taddr_q, data_q, rx_byte;
  logic [DIV_W-1:0]  div_q;
  logic              err_q;
  logic              eng_active, eng_err, rx_valid, tick;
  logic              go, wr_ok, busy_vis, err_vis;

  assign wr_ok    = reg_we_i && !eng_active;
  assign go       = wr_ok && (reg_addr_i == REG_CMD) && reg_wdata_i[CMD_RUN];
  assign busy_vis = eng_active || go;
  assign err_vis  = err_q && !go;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      taddr_q <= '0;
      data_q  <= '0;
      div_q   <= DIV_RST;
      err_q   <= 1'b0;
    end else begin
      if (wr_ok && reg_addr_i == REG_TADDR) taddr_q <= reg_wdata_i;
      if (wr_ok && reg_addr_i == REG_DIV)   div_q   <= DIV_W'(reg_wdata_i);
      if (rx_valid)                          data_q  <= rx_byte;
      else if (wr_ok && reg_addr_i == REG_DATA) data_q <= reg_wdata_i;
      if (go)           err_q <= 1'b0;
      else if (eng_err) err_q <= 1'b1;
    end
  end

  always_comb begin
    case (reg_addr_i)
      REG_TADDR: reg_rdata_o = taddr_q;
      REG_DATA:  reg_rdata_o = data_q;
      REG_CMD:   reg_rdata_o = {6'b0, err_vis, busy_vis};
      default:   reg_rdata_o = 8'(div_q);
    endcase
  end

  i2c_quarter_tick #(.DIV_W(DIV_W)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (eng_active),
    .div_i  (div_q),
    .tick_o (tick)
  );

  i2c_byte_engine #(.BYTE_W(BYTE_W)) u_eng (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick),
    .go_i        (go),
    .start_i     (reg_wdata_i[CMD_START]),
    .stop_i      (reg_wdata_i[CMD_STOP]),
    .ack_i       (reg_wdata_i[CMD_ACK]),
    .addr_byte_i (taddr_q),
    .tx_byte_i   (data_q),
    .sda_i       (sda_i),
    .active_o    (eng_active),
    .err_o       (eng_err),
    .rx_byte_o   (rx_byte),
    .rx_valid_o  (rx_valid),
    .scl_low_o   (scl_oe_o),
    .sda_low_o   (sda_oe_o)
  );

  p_busy_follows_run_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go |=> eng_active);

  p_err_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go |=> !err_q);

  p_div_frozen_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eng_active && $past(eng_active)) |-> $stable(div_q));
endmodule

// File: tb/sim_i2c_cmd_master.sv
module sim_i2c_cmd_master;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic       we = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  wire  [7:0] rdata;
  wire        scl_oe, sda_oe;
  logic       slv_low = 1'b0;
  wire        scl_w = ~scl_oe;
  wire        sda_w = ~sda_oe & ~slv_low;

  i2c_cmd_master u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .scl_oe_o(scl_oe),
    .sda_oe_o(sda_oe), .sda_i(sda_w)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  // ---------------- target model ----------------
  localparam logic [6:0] TGT = 7'h3A;
  int starts = 0, stops = 0, bitn = 0, wr_cnt = 0, mack_cnt = 0, rd_idx = 0;
  int nack_at = -1;
  bit nack_addr = 0, act = 0, in_addr = 0, rd_mode = 0, mack_ok = 0;
  logic [7:0] sh = 0, rd_cur = 0, rd_base = 0, last_addr = 0;
  logic [7:0] wr_log [16];
  bit mack_log [16];
  realtime t_last = 0, t_prev = 0;

  function automatic logic [7:0] rd_val(input int i);
    return rd_base + 8'(i * 3);
  endfunction

  always @(negedge sda_w) if (rst_n && scl_w === 1'b1) begin
    starts++; bitn = 0; in_addr = 1; act = 1; slv_low = 0;
  end
  always @(posedge sda_w) if (rst_n && scl_w === 1'b1) begin
    stops++; act = 0; slv_low = 0;
  end
  always @(posedge scl_w) if (rst_n) begin
    t_prev = t_last; t_last = $realtime;
    if (act) begin
      if (bitn < 8) sh = {sh[6:0], sda_w};
      else if (!in_addr && rd_mode) begin
        mack_ok = (sda_w == 1'b0);
        mack_log[mack_cnt] = mack_ok; mack_cnt++;
      end
      bitn++;
    end
  end
  always @(negedge scl_w) if (rst_n && act) begin
    if (bitn == 8) begin
      if (in_addr) begin
        last_addr = sh; rd_mode = sh[0];
        if (sh[7:1] == TGT && !nack_addr) slv_low = 1;
        else begin slv_low = 0; act = 0; end
      end else if (!rd_mode) begin
        wr_log[wr_cnt] = sh; slv_low = (wr_cnt != nack_at); wr_cnt++;
      end else begin
        slv_low = 0; rd_idx++;
      end
    end else if (bitn == 9) begin
      bitn = 0;
      if (in_addr) begin
        in_addr = 0;
        if (rd_mode) begin rd_cur = rd_val(rd_idx); slv_low = ~rd_cur[7]; end
        else slv_low = 0;
      end else if (rd_mode && mack_ok) begin
        rd_cur = rd_val(rd_idx); slv_low = ~rd_cur[7];
      end else slv_low = 0;
    end else if (bitn >= 1 && bitn <= 7 && !in_addr && rd_mode) begin
      slv_low = ~rd_cur[7-bitn];
    end
  end

  task automatic clear_tgt();
    starts = 0; stops = 0; wr_cnt = 0; mack_cnt = 0; rd_idx = 0;
    nack_at = -1; nack_addr = 0; mack_ok = 0;
  endtask

  // ---------------- helpers ----------------
  task automatic chk(input string req, input logic [31:0] act_v, input logic [31:0] exp_v);
    checks++;
    if (act_v !== exp_v) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act_v, exp_v);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk); addr = a; #1; v = rdata;
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    int n = 0;
    do begin rd(2'd2, s); n++; end while (s[0] && n < 40000);
    repeat (3) @(negedge clk);
  endtask

  logic [7:0] v;

  task automatic single_write(input logic [7:0] d, input logic [7:0] cmd);
    wr(2'd0, {TGT, 1'b0}); wr(2'd1, d); wr(2'd2, cmd); wait_idle();
  endtask

  initial begin
    #(8 * 190000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    @(negedge clk);
    chk("R1 scl_oe", scl_oe, 0);
    chk("R1 sda_oe", sda_oe, 0);
    rd(2'd0, v); chk("R1 taddr", v, 0);
    rd(2'd1, v); chk("R1 data", v, 0);
    rd(2'd2, v); chk("R1 status", v, 0);
    rd(2'd3, v); chk("R1 div", v, 4);

    // R2 busy visible in the write cycle
    clear_tgt();
    wr(2'd0, {TGT, 1'b0}); wr(2'd1, 8'h5A);
    @(negedge clk); we = 1; addr = 2'd2; wdata = 8'h07; #1;
    chk("R2 busy in write cycle", rdata[1:0], 2'b01);
    @(negedge clk); we = 0; #1;
    chk("R2 busy after write", rdata[0], 1);
    wait_idle();
    chk("R3 first byte", wr_log[0], 8'h5A);

    // R3 R9 R10 sweep over divider and data
    for (int dv = 0; dv < 4; dv++) begin
      wr(2'd3, 8'(dv));
      for (int k = 0; k < 6; k++) begin
        logic [7:0] d;
        d = 8'(k * 8'h2B) ^ 8'(dv * 8'h11);
        clear_tgt();
        single_write(d, 8'h07);
        chk("R3 addr byte", last_addr, {TGT, 1'b0});
        chk("R3 byte count", wr_cnt, 1);
        chk("R3 data byte", wr_log[0], d);
        chk("R9 starts", starts, 1);
        chk("R9 stops", stops, 1);
        chk("R3 released", {scl_oe, sda_oe}, 2'b00);
        rd(2'd2, v); chk("R3 status", v, 0);
        chk("R10 scl period", int'((t_last - t_prev) / 8.0), 4 * (dv + 1));
      end
    end
    wr(2'd3, 8'd1);

    // R4 burst with held bus
    begin
      logic [7:0] b [4];
      b[0] = 8'hA5; b[1] = 8'h00; b[2] = 8'hFF; b[3] = 8'h3C;
      clear_tgt();
      wr(2'd0, {TGT, 1'b0});
      for (int i = 0; i < 4; i++) begin
        wr(2'd1, b[i]);
        wr(2'd2, (i == 0) ? 8'h03 : (i == 3) ? 8'h05 : 8'h01);
        wait_idle();
        if (i < 3) begin
          chk("R4 scl held low", scl_oe, 1);
          chk("R4 no stop", stops, 0);
        end
      end
      chk("R4 byte count", wr_cnt, 4);
      for (int i = 0; i < 4; i++) chk("R4 byte order", wr_log[i], b[i]);
      chk("R4 one start", starts, 1);
      chk("R4 final stop", stops, 1);
    end

    // R5 repeated start then R6 read two bytes
    clear_tgt(); rd_base = 8'h6D;
    single_write(8'h10, 8'h03);
    wr(2'd0, {TGT, 1'b1}); wr(2'd2, 8'h0B); wait_idle();
    chk("R5 repeated start", starts, 2);
    chk("R5 no stop", stops, 0);
    rd(2'd1, v); chk("R6 read byte0", v, rd_val(0));
    chk("R6 master ack", mack_log[0], 1);
    wr(2'd2, 8'h05); wait_idle();
    rd(2'd1, v); chk("R6 read byte1", v, rd_val(1));
    chk("R6 master nack", mack_log[1], 0);
    chk("R6 stop", stops, 1);

    // R6 single read sweep
    for (int k = 0; k < 5; k++) begin
      clear_tgt(); rd_base = 8'(k * 8'h47 + 8'h81);
      wr(2'd0, {TGT, 1'b1}); wr(2'd2, 8'h07); wait_idle();
      rd(2'd1, v); chk("R6 single read", v, rd_base);
      chk("R6 read stop", stops, 1);
    end

    // R7 address NACK
    clear_tgt(); nack_addr = 1;
    single_write(8'h99, 8'h07);
    rd(2'd2, v); chk("R7 error set", v, 8'h02);
    chk("R7 stop", stops, 1);
    chk("R7 released", {scl_oe, sda_oe}, 2'b00);
    chk("R7 no data", wr_cnt, 0);
    clear_tgt();
    @(negedge clk); we = 1; addr = 2'd2; wdata = 8'h07; #1;
    chk("R7 error cleared", rdata[1:0], 2'b01);
    @(negedge clk); we = 0;
    wait_idle();
    rd(2'd2, v); chk("R7 clean status", v, 0);

    // R8 data NACK on a STOP=0 command
    clear_tgt(); nack_at = 1;
    wr(2'd0, {TGT, 1'b0});
    wr(2'd1, 8'h11); wr(2'd2, 8'h03); wait_idle();
    wr(2'd1, 8'h22); wr(2'd2, 8'h01); wait_idle();
    rd(2'd2, v); chk("R8 error set", v, 8'h02);
    chk("R8 stop", stops, 1);
    chk("R8 released", scl_oe, 0);

    // R11 writes while busy ignored
    clear_tgt();
    wr(2'd0, {TGT, 1'b0}); wr(2'd1, 8'hC3); wr(2'd2, 8'h07);
    wr(2'd1, 8'h3C); wr(2'd2, 8'h03); wr(2'd3, 8'd9); wr(2'd0, 8'h00);
    wait_idle();
    chk("R11 one byte", wr_cnt, 1);
    chk("R11 byte", wr_log[0], 8'hC3);
    chk("R11 stop", stops, 1);
    rd(2'd1, v); chk("R11 data kept", v, 8'hC3);
    rd(2'd3, v); chk("R11 div kept", v, 1);
    rd(2'd0, v); chk("R11 addr kept", v, {TGT, 1'b0});

    // R12 high-speed flag and RUN=0
    clear_tgt();
    single_write(8'h7E, 8'h17);
    chk("R12 hs byte", wr_log[0], 8'h7E);
    chk("R12 hs stop", stops, 1);
    clear_tgt();
    wr(2'd2, 8'h06);
    rd(2'd2, v); chk("R12 no run busy", v, 0);
    repeat (50) @(negedge clk);
    chk("R12 no run bus", {scl_oe, sda_oe}, 2'b00);
    chk("R12 no run start", starts, 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule